// File: doc/BRIEF.md
# ATA Host Channel Sequencer

The block drives the host side of one parallel ATA channel. A local agent asks for single register accesses in programmed I/O mode. Each request carries a direction, a chip-select choice, a 3-bit register address and, for writes, 16 bits of data. The agent can also ask for an Ultra DMA burst in either direction. The sequencer turns each request into the line sequence the drive expects. It produces the command strobes, the chip selects, the address, the DMA acknowledge and the enable for the shared data lines. It samples the drive's DMA request and the drive's data strobe.

The two command strobes change role with the mode. In a programmed I/O cycle they are the plain active-low read and write commands. In a DMA read burst the read strobe becomes the host-ready line, held low while the host accepts data. In a DMA write burst the read strobe becomes the host data strobe, and each of its transitions carries one word. In both DMA directions the write strobe becomes the stop line. At the end of each access or burst the block gives a one-cycle done pulse, together with the captured data and the number of words moved.

Top module: `ata_chan_seq`

## Requirements
- R1: During reset, after reset and while `pwr_down_i` is high, `rd_strb_n_o`, `wr_strb_n_o` and `dack_n_o` are 1, `cs_n_o` is 2'b11, `addr_o` is 0 and `data_oe_o` is 0. The same levels hold whenever the sequencer is idle.
- R2: A register read drives `rd_strb_n_o` low for max(`act_cnt_i`,1) cycles. The sequencer captures `data_i` at the clock edge where the strobe returns high, and reports that word on `rdata_o` with the done pulse.
- R3: A register write drives `wr_strb_n_o` low for max(`act_cnt_i`,1) cycles and never lowers `rd_strb_n_o`. It holds `data_oe_o` high with `data_o` equal to the request data for the whole access, recovery included.
- R4: After the active phase both strobes stay high for max(`rec_cnt_i`,1) recovery cycles while the address and chip select are held. Then `done_o` pulses with `xfer_cnt_o` = 1. Both counts are sampled when the request is accepted.
- R5: `req_cs_i`=0 drives `cs_n_o[0]` low and `req_cs_i`=1 drives `cs_n_o[1]` low, for the whole access. At most one chip select is ever low.
- R6: After `dma_start_i` is accepted, `dack_n_o` stays high until `drv_req_i` is seen high. It then goes low on the next edge. While `dack_n_o` is low, both chip selects stay high.
- R7: In a read burst (`dma_write_i`=0 at start), `rd_strb_n_o` is the host-ready line: 0 while `dma_pause_i` is low and 1 while it is high.
- R8: In a read burst, every transition of `drv_strb_i` sampled while the burst runs (including during a pause) captures `data_i` and counts one word. The last word is reported on `rdata_o` with the done pulse.
- R9: In a write burst, `rd_strb_n_o` starts at 1 and toggles on every unpaused clock. Each toggle puts a new `dma_wdata_i` word on `data_o` and counts it, with `data_oe_o` high throughout the burst.
- R10: While `dma_pause_i` is high in a write burst the strobe holds its level. After the pause it resumes toggling from that level.
- R11: `dma_stop_i` during a burst lowers `wr_strb_n_o` on the next edge. The sequencer holds it low until `drv_req_i` is seen low. Then `dack_n_o` returns high and `done_o` pulses with `xfer_cnt_o` equal to the burst's word count.
- R12: Requests are accepted only while both engines are idle and `pwr_down_i` is low. Other requests are ignored. A register request wins over a simultaneous burst start.
- R13: `done_o` is high for exactly one cycle per completed access or burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down: forces the drive-side lines inactive and blocks requests |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_cs_i | input | 1 | Chip select choice (0 or 1) |
| req_addr_i | input | 3 | Register address |
| req_wdata_i | input | 16 | Register write data |
| act_cnt_i | input | 4 | Strobe active width in clocks (0 counts as 1) |
| rec_cnt_i | input | 4 | Recovery width in clocks (0 counts as 1) |
| dma_start_i | input | 1 | Burst start request |
| dma_write_i | input | 1 | Burst direction, 1 = host to drive |
| dma_pause_i | input | 1 | Pause request for the running burst |
| dma_stop_i | input | 1 | Terminate the running burst |
| dma_wdata_i | input | 16 | Next word for a write burst |
| drv_req_i | input | 1 | Drive DMA request |
| drv_strb_i | input | 1 | Drive data strobe during a read burst |
| data_i | input | 16 | Data lines from the drive |
| rd_strb_n_o | output | 1 | Read command, host-ready, or host data strobe, by mode |
| wr_strb_n_o | output | 1 | Write command, or stop in a burst |
| cs_n_o | output | 2 | Active-low chip selects |
| addr_o | output | 3 | Register address to the drive |
| dack_n_o | output | 1 | Active-low DMA acknowledge |
| data_o | output | 16 | Data lines toward the drive |
| data_oe_o | output | 1 | Output enable for the data lines |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read word, valid with done_o |
| xfer_cnt_o | output | 16 | Words moved, valid with done_o |

## Verification
The properties assume `pwr_down_i` rises only while the sequencer is idle. They also assume the drive withdraws its request only after the host has raised stop, and that `drv_strb_i` changes at most once per clock. The stimulus follows these rules. It raises power-down only between transactions. In each burst it drops the drive request after the stop pulse, or together with it. It toggles the drive strobe at most once per cycle. Requests sent while the block is busy or powered down are driven on purpose, so that their lack of effect shows up at the ports.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  typedef enum logic [1:0] {P_IDLE, P_ACT, P_REC} pio_st_e;
  typedef enum logic [1:0] {D_IDLE, D_WREQ, D_RUN, D_STOP} dma_st_e;

  typedef struct packed {
    logic       rd_n;
    logic       wr_n;
    logic [1:0] cs_n;
    logic [2:0] addr;
    logic       dack_n;
    logic       oe;
  } bus_t;

  localparam bus_t BUS_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, cs_n: 2'b11,
                                addr: 3'd0, dack_n: 1'b1, oe: 1'b0};
endpackage

// File: rtl/ata_pio_ctl.sv
module ata_pio_ctl
  import ata_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic          cs_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] act_i,
  input  logic [TW-1:0] rec_i,
  input  logic [DW-1:0] data_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] wdata_o,
  output bus_t          bus_o
);
  pio_st_e       st_q;
  logic          wr_q, cs_q, done_q;
  logic [2:0]    addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [TW-1:0] tcnt_q, rec_q;

  // programmed width minus one, zero clamps to a single clock
  function automatic logic [TW-1:0] width_m1(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - TW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= P_IDLE;
      wr_q    <= 1'b0;
      cs_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      tcnt_q  <= '0;
      rec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        P_IDLE: if (start_i) begin
          st_q    <= P_ACT;
          wr_q    <= wr_i;
          cs_q    <= cs_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          tcnt_q  <= width_m1(act_i);
          rec_q   <= width_m1(rec_i);
        end
        P_ACT: if (tcnt_q == '0) begin
          st_q   <= P_REC;
          tcnt_q <= rec_q;
          if (!wr_q) rdata_q <= data_i;  // strobe rises at this edge
        end else begin
          tcnt_q <= tcnt_q - TW'(1);
        end
        P_REC: if (tcnt_q == '0) begin
          st_q   <= P_IDLE;
          done_q <= 1'b1;
        end else begin
          tcnt_q <= tcnt_q - TW'(1);
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_o = BUS_IDLE;
    if (st_q != P_IDLE) begin
      bus_o.cs_n = cs_q ? 2'b01 : 2'b10;
      bus_o.addr = addr_q;
      bus_o.oe   = wr_q;
      bus_o.rd_n = !(st_q == P_ACT && !wr_q);
      bus_o.wr_n = !(st_q == P_ACT && wr_q);
    end
  end

  assign idle_o  = (st_q == P_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/ata_udma_ctl.sv
module ata_udma_ctl
  import ata_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int XW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic          pause_i,
  input  logic          stop_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          drv_req_i,
  input  logic          drv_strb_i,
  input  logic [DW-1:0] data_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] word_o,
  output logic [XW-1:0] cnt_o,
  output bus_t          bus_o
);
  dma_st_e       st_q;
  logic          dir_wr_q, strb_q, ds_q, done_q, active;
  logic [DW-1:0] word_q, rdata_q;
  logic [XW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= D_IDLE;
      dir_wr_q <= 1'b0;
      strb_q   <= 1'b1;
      ds_q     <= 1'b0;
      done_q   <= 1'b0;
      word_q   <= '0;
      rdata_q  <= '0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      ds_q   <= drv_strb_i;
      unique case (st_q)
        D_IDLE: if (start_i) begin
          st_q     <= D_WREQ;
          dir_wr_q <= write_i;
          strb_q   <= 1'b1;
          cnt_q    <= '0;
        end
        D_WREQ: if (drv_req_i) st_q <= D_RUN;
        D_RUN: begin
          if (stop_i) begin
            st_q <= D_STOP;
          end else if (dir_wr_q) begin
            if (!pause_i) begin
              strb_q <= ~strb_q;
              word_q <= wdata_i;
              cnt_q  <= cnt_q + XW'(1);
            end
          end else if (drv_strb_i != ds_q) begin
            rdata_q <= data_i;
            cnt_q   <= cnt_q + XW'(1);
          end
        end
        D_STOP: if (!drv_req_i) begin
          st_q   <= D_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign active = (st_q == D_RUN) || (st_q == D_STOP);

  always_comb begin
    bus_o = BUS_IDLE;
    if (active) begin
      bus_o.dack_n = 1'b0;
      bus_o.wr_n   = (st_q != D_STOP);
      bus_o.oe     = dir_wr_q;
      bus_o.rd_n   = dir_wr_q ? strb_q : ((st_q == D_STOP) || pause_i);
    end
  end

  assign idle_o  = (st_q == D_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign word_o  = word_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ata_chan_seq.sv
module ata_chan_seq
  import ata_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 4,
  parameter int XW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_down_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_cs_i,
  input  logic [2:0]    req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [TW-1:0] act_cnt_i,
  input  logic [TW-1:0] rec_cnt_i,
  input  logic          dma_start_i,
  input  logic          dma_write_i,
  input  logic          dma_pause_i,
  input  logic          dma_stop_i,
  input  logic [DW-1:0] dma_wdata_i,
  input  logic          drv_req_i,
  input  logic          drv_strb_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_strb_n_o,
  output logic          wr_strb_n_o,
  output logic [1:0]    cs_n_o,
  output logic [2:0]    addr_o,
  output logic          dack_n_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [XW-1:0] xfer_cnt_o
);
  logic          pio_idle, dma_idle, both_idle, pio_go, dma_go;
  logic          pio_done, dma_done;
  logic [DW-1:0] pio_rdata, pio_wdata, dma_rdata, dma_word;
  logic [XW-1:0] dma_cnt;
  bus_t          pio_bus, dma_bus, bus_sel;

  assign both_idle = pio_idle && dma_idle;
  assign pio_go    = both_idle && !pwr_down_i && req_valid_i;
  assign dma_go    = both_idle && !pwr_down_i && !req_valid_i && dma_start_i;

  ata_pio_ctl #(.DW(DW), .TW(TW)) u_pio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pio_go),
    .wr_i    (req_write_i),
    .cs_i    (req_cs_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .act_i   (act_cnt_i),
    .rec_i   (rec_cnt_i),
    .data_i  (data_i),
    .idle_o  (pio_idle),
    .done_o  (pio_done),
    .rdata_o (pio_rdata),
    .wdata_o (pio_wdata),
    .bus_o   (pio_bus)
  );

  ata_udma_ctl #(.DW(DW), .XW(XW)) u_dma (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (dma_go),
    .write_i    (dma_write_i),
    .pause_i    (dma_pause_i),
    .stop_i     (dma_stop_i),
    .wdata_i    (dma_wdata_i),
    .drv_req_i  (drv_req_i),
    .drv_strb_i (drv_strb_i),
    .data_i     (data_i),
    .idle_o     (dma_idle),
    .done_o     (dma_done),
    .rdata_o    (dma_rdata),
    .word_o     (dma_word),
    .cnt_o      (dma_cnt),
    .bus_o      (dma_bus)
  );

  always_comb begin
    if (!pio_idle)      bus_sel = pio_bus;
    else if (!dma_idle) bus_sel = dma_bus;
    else                bus_sel = BUS_IDLE;
    if (pwr_down_i)     bus_sel = BUS_IDLE;
  end

  assign rd_strb_n_o = bus_sel.rd_n;
  assign wr_strb_n_o = bus_sel.wr_n;
  assign cs_n_o      = bus_sel.cs_n;
  assign addr_o      = bus_sel.addr;
  assign dack_n_o    = bus_sel.dack_n;
  assign data_oe_o   = bus_sel.oe;
  assign data_o      = pio_idle ? dma_word : pio_wdata;
  assign done_o      = pio_done || dma_done;
  assign rdata_o     = pio_done ? pio_rdata : dma_rdata;
  assign xfer_cnt_o  = pio_done ? XW'(1) : dma_cnt;
endmodule

// File: rtl/ata_chan_seq_chk.sv
module ata_chan_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_down_i,
  input logic       dma_pause_i,
  input logic       dma_stop_i,
  input logic       rd_strb_n_o,
  input logic       wr_strb_n_o,
  input logic [1:0] cs_n_o,
  input logic       dack_n_o,
  input logic       data_oe_o,
  input logic       done_o
);
  AST_PDN_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (rd_strb_n_o && wr_strb_n_o && dack_n_o && cs_n_o == 2'b11 && !data_oe_o)); // R1

  AST_PIO_WR_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && dack_n_o) |-> rd_strb_n_o); // R3

  AST_CS_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1); // R5

  AST_DACK_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_n_o |-> (cs_n_o == 2'b11)); // R6

  AST_WR_BURST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dack_n_o && data_oe_o && wr_strb_n_o && !dma_pause_i && !dma_stop_i && !pwr_down_i)
      |=> (dack_n_o || rd_strb_n_o != $past(rd_strb_n_o))); // R9

  AST_WR_BURST_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dack_n_o && data_oe_o && dma_pause_i && !pwr_down_i)
      |=> (dack_n_o || $stable(rd_strb_n_o))); // R10

  AST_STOP_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dack_n_o && wr_strb_n_o && dma_stop_i && !pwr_down_i) |=> !wr_strb_n_o); // R11

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dack_n_o && !wr_strb_n_o && !pwr_down_i) |=> (dack_n_o || !wr_strb_n_o)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
endmodule

bind ata_chan_seq ata_chan_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_down_i  (pwr_down_i),
  .dma_pause_i (dma_pause_i),
  .dma_stop_i  (dma_stop_i),
  .rd_strb_n_o (rd_strb_n_o),
  .wr_strb_n_o (wr_strb_n_o),
  .cs_n_o      (cs_n_o),
  .dack_n_o    (dack_n_o),
  .data_oe_o   (data_oe_o),
  .done_o      (done_o)
);

// File: tb/sim_ata_chan_seq.sv
module sim_ata_chan_seq;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int XW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic          pdn, req_valid, req_write, req_cs;
  logic [2:0]    req_addr;
  logic [DW-1:0] req_wdata, dma_wdata, dd_in;
  logic [TW-1:0] act_cnt, rec_cnt;
  logic          dma_start, dma_write, dma_pause, dma_stop, drv_req, drv_strb;

  logic          rd_n, wr_n, dack_n, oe, done;
  logic [1:0]    cs_n;
  logic [2:0]    addr;
  logic [DW-1:0] dout, rdata;
  logic [XW-1:0] xcnt;

  ata_chan_seq #(.DW(DW), .TW(TW), .XW(XW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_down_i(pdn),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_cs_i(req_cs),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .act_cnt_i(act_cnt), .rec_cnt_i(rec_cnt),
    .dma_start_i(dma_start), .dma_write_i(dma_write), .dma_pause_i(dma_pause),
    .dma_stop_i(dma_stop), .dma_wdata_i(dma_wdata),
    .drv_req_i(drv_req), .drv_strb_i(drv_strb), .data_i(dd_in),
    .rd_strb_n_o(rd_n), .wr_strb_n_o(wr_n), .cs_n_o(cs_n), .addr_o(addr),
    .dack_n_o(dack_n), .data_o(dout), .data_oe_o(oe), .done_o(done),
    .rdata_o(rdata), .xfer_cnt_o(xcnt)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 active, 2 recovery, 3 wait drive, 4 burst, 5 stopping
  int ms, tc, rec_w, m_n, m_kind;
  logic m_wr, m_cs, m_dwr, m_strb, m_dsp, m_done;
  logic [2:0] m_addr;
  logic [DW-1:0] m_wd, m_rd, m_drd, m_dd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; tc = 0; rec_w = 0; m_n = 0; m_kind = 0;
      m_wr = 0; m_cs = 0; m_dwr = 0; m_strb = 1; m_dsp = 0; m_done = 0;
      m_addr = 0; m_wd = 0; m_rd = 0; m_drd = 0; m_dd = 0;
    end else begin
      m_done = 0;
      case (ms)
        0: if (!pdn && req_valid) begin
             ms = 1; m_wr = req_write; m_cs = req_cs; m_addr = req_addr; m_wd = req_wdata;
             tc = (act_cnt == 0) ? 1 : int'(act_cnt);
             rec_w = (rec_cnt == 0) ? 1 : int'(rec_cnt);
           end else if (!pdn && dma_start) begin
             ms = 3; m_dwr = dma_write; m_strb = 1; m_n = 0;
           end
        1: begin
             tc--;
             if (tc == 0) begin
               if (!m_wr) m_rd = dd_in;
               ms = 2; tc = rec_w;
             end
           end
        2: begin
             tc--;
             if (tc == 0) begin ms = 0; m_done = 1; m_kind = 0; end
           end
        3: if (drv_req) ms = 4;
        4: if (dma_stop) ms = 5;
           else if (m_dwr) begin
             if (!dma_pause) begin m_strb = !m_strb; m_dd = dma_wdata; m_n++; end
           end else if (drv_strb != m_dsp) begin
             m_drd = dd_in; m_n++;
           end
        5: if (!drv_req) begin ms = 0; m_done = 1; m_kind = 1; end
        default: ms = 0;
      endcase
      m_dsp = drv_strb;
    end
  end

  always @(negedge clk) begin
    logic e_rd, e_wr, e_ack, e_oe;
    logic [1:0] e_cs;
    logic [2:0] e_da;
    logic [DW-1:0] e_dd;
    string tag;
    e_rd = 1; e_wr = 1; e_ack = 1; e_oe = 0; e_cs = 2'b11; e_da = 0; e_dd = 0;
    tag = "R1 R12";
    case (ms)
      1, 2: begin
        e_cs = m_cs ? 2'b01 : 2'b10; e_da = m_addr; e_oe = m_wr; e_dd = m_wd;
        if (ms == 1) begin
          if (m_wr) e_wr = 0; else e_rd = 0;
          tag = m_wr ? "R3" : "R2";
        end else tag = "R4";
      end
      3: tag = "R6";
      4: begin
        e_ack = 0; e_oe = m_dwr; e_dd = m_dd;
        e_rd = m_dwr ? m_strb : dma_pause;
        tag = m_dwr ? (dma_pause ? "R10" : "R9") : "R7";
      end
      5: begin
        e_ack = 0; e_wr = 0; e_oe = m_dwr; e_dd = m_dd;
        e_rd = m_dwr ? m_strb : 1'b1;
        tag = "R11";
      end
      default: ;
    endcase
    if (pdn) begin
      e_rd = 1; e_wr = 1; e_ack = 1; e_oe = 0; e_cs = 2'b11; e_da = 0; tag = "R1";
    end
    chk(tag, "rd_strb_n", 32'(rd_n), 32'(e_rd));
    chk(tag, "wr_strb_n", 32'(wr_n), 32'(e_wr));
    chk(tag, "dack_n", 32'(dack_n), 32'(e_ack));
    chk(tag, "data_oe", 32'(oe), 32'(e_oe));
    chk("R5", "cs_n", 32'(cs_n), 32'(e_cs));
    chk(tag, "addr", 32'(addr), 32'(e_da));
    if (e_oe) chk(tag, "data_o", 32'(dout), 32'(e_dd));
    chk("R13", "done", 32'(done), 32'(m_done));
    if (m_done && done) begin
      if (m_kind == 0) begin
        chk("R2", "rdata", 32'(rdata), 32'(m_rd));
        chk("R4", "xfer_cnt", 32'(xcnt), 32'd1);
      end else begin
        chk("R8", "rdata", 32'(rdata), 32'(m_drd));
        chk("R11", "xfer_cnt", 32'(xcnt), 32'(m_n));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pio(input logic wr, input logic cs, input logic [2:0] a,
                     input logic [DW-1:0] wd, input logic [TW-1:0] act, input logic [TW-1:0] rec);
    req_write = wr; req_cs = cs; req_addr = a; req_wdata = wd; act_cnt = act; rec_cnt = rec;
    req_valid = 1; cyc(1); req_valid = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    pdn = 0; req_valid = 0; req_write = 0; req_cs = 0; req_addr = 0; req_wdata = 0;
    act_cnt = 0; rec_cnt = 0; dma_start = 0; dma_write = 0; dma_pause = 0; dma_stop = 0;
    dma_wdata = 0; drv_req = 0; drv_strb = 0; dd_in = 0;
    #1 rst_n = 0;
    cyc(3); rst_n = 1; cyc(3);              // R1 reset levels

    // R2 read with capture at strobe rise, data changing during active phase
    dd_in = 16'hA5A5;
    pio(0, 0, 3'd5, 16'h0, 4'd3, 4'd2);
    cyc(1); dd_in = 16'h1111; cyc(1); dd_in = 16'h2222; cyc(1); dd_in = 16'h3333;
    cyc(8);
    // R3 R4 write with minimum widths, second chip select
    pio(1, 1, 3'd2, 16'hBEEF, 4'd0, 4'd0);
    cyc(6);
    // R4 longer recovery
    dd_in = 16'h1234;
    pio(0, 1, 3'd7, 16'h0, 4'd1, 4'd4);
    cyc(9);
    // R12 requests while busy are ignored
    pio(1, 0, 3'd1, 16'hCAFE, 4'd2, 4'd3);
    cyc(1); req_valid = 1; dma_start = 1; req_addr = 3'd6;
    cyc(2); req_valid = 0; dma_start = 0;
    cyc(10);
    // R12 register request wins over burst start
    dma_start = 1;
    pio(0, 0, 3'd3, 16'h0, 4'd2, 4'd1);
    dma_start = 0;
    cyc(8);
    // R12 R1 power-down blocks requests and holds lines inactive
    pdn = 1; cyc(1);
    req_valid = 1; dma_start = 1; cyc(2);
    req_valid = 0; dma_start = 0; cyc(2);
    pdn = 0; cyc(3);

    // R6 R7 R8 R11 read burst, drive request late
    dma_write = 0; dma_start = 1; cyc(1); dma_start = 0;
    cyc(3); drv_req = 1; cyc(2);
    for (int i = 0; i < 5; i++) begin dd_in = 16'h1000 + 16'(i); drv_strb = ~drv_strb; cyc(2); end
    dma_pause = 1; cyc(2);
    dd_in = 16'h2000; drv_strb = ~drv_strb; cyc(2);
    dma_pause = 0;
    for (int i = 0; i < 3; i++) begin dd_in = 16'h2100 + 16'(i); drv_strb = ~drv_strb; cyc(1); end
    dma_stop = 1; cyc(1); dma_stop = 0;
    cyc(3); drv_req = 0; cyc(4);

    // R9 R10 R11 write burst with odd toggle count before pause
    dma_write = 1; drv_req = 1; dma_start = 1; cyc(1); dma_start = 0;
    cyc(1);
    for (int i = 0; i < 3; i++) begin dma_wdata = 16'h3000 + 16'(i); cyc(1); end
    dma_pause = 1; cyc(3); dma_pause = 0;
    for (int i = 0; i < 4; i++) begin dma_wdata = 16'h3100 + 16'(i); cyc(1); end
    dma_stop = 1; cyc(1); dma_stop = 0;
    cyc(2); drv_req = 0; cyc(4);

    // R11 stop during pause, drive request already gone
    dma_write = 1; drv_req = 1; dma_start = 1; cyc(1); dma_start = 0;
    cyc(3); dma_pause = 1; cyc(1);
    dma_stop = 1; drv_req = 0; cyc(1); dma_stop = 0; dma_pause = 0;
    cyc(4);

    // R8 short read burst, strobe each cycle
    dma_write = 0; drv_req = 1; dma_start = 1; cyc(1); dma_start = 0; cyc(2);
    for (int i = 0; i < 4; i++) begin dd_in = 16'h4000 + 16'(i); drv_strb = ~drv_strb; cyc(1); end
    dma_stop = 1; cyc(1); dma_stop = 0; drv_req = 0;
    cyc(5);

    summary();
    $finish;
  end
endmodule